// File: doc/BRIEF.md
# Character Tape Reader Controller

This block connects a character-at-a-time tape reader to a 16-bit peripheral register bus. Software sees two word registers: a control/status word and a read-only data buffer that holds the last character. Setting the start bit in the status word asks the reader for one character. The block then runs the busy, done and error sequence, loads the buffer and, if enabled, raises an interrupt request.

The link to the reader is a small handshake. The block sends a one-cycle request strobe. The reader later returns a response that carries either a character or an end-of-media flag. A separate level input tells whether media is loaded. If the start bit is written with no media loaded, the read fails at once without a strobe. A read of the data buffer acknowledges the character by clearing done and withdrawing the interrupt request.

Top module: `ptr_reader_if`

## Requirements
- R1: Byte address bits 4:1 select the register. Word index 4 is the status word (byte address 8) and word index 5 is the data buffer (byte address 10). Any other index in the 5-bit space gives `bus_nxm`=1 for that access and changes no state. Decoded accesses give `bus_nxm`=0.
- R2: A status read returns error at bit 15, busy at bit 11, done at bit 7 and interrupt-enable at bit 6, with every other bit 0. This includes the start bit, bit 0.
- R3: A word or even-byte write to the status word with bit 0 set clears done, sets busy and withdraws the interrupt request. If media is present, `rdr_strobe` is 1 for exactly the one cycle that follows the write.
- R4: If media is absent in the cycle after the start write, the read completes on that edge. Busy clears, error sets, no strobe is issued, and the request rises if interrupt-enable is 1.
- R5: A response with `rdr_resp_eom`=0 completes the read. Busy and error clear, done sets and the buffer takes `rdr_resp_char`. A response with `rdr_resp_eom`=1 clears busy, sets error and leaves done at 0 and the buffer unchanged. Responses are only taken while a strobed read is pending.
- R6: Completion raises `irq` when interrupt-enable is 1 and leaves it low when interrupt-enable is 0.
- R7: A read of the data buffer returns the character in bits 7:0 with bits 15:8 zero. It clears done and withdraws the request.
- R8: Writes to the data buffer change neither the buffer nor the status word.
- R9: Writing interrupt-enable as 0 withdraws the request. Writing it as 1 when it was 0 and error or done is set raises the request on that edge. Writing 1 when it was already 1 does not raise it.
- R10: A byte write to the odd (high) byte of the status word (byte address 9) has no effect.
- R11: Synchronous reset (`rst_n`=0) clears busy, done, interrupt-enable, the buffer and the request. It sets error to the inverse of `rdr_media` and abandons any pending read, so a later response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_byte | input | 1 | 1 for a byte access, lane picked by bus_addr[0] |
| bus_addr | input | 5 | Byte address within the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| bus_nxm | output | 1 | Nonexistent-register response for the access |
| rdr_media | input | 1 | Media is loaded in the reader |
| rdr_strobe | output | 1 | One-cycle request for a character |
| rdr_resp_valid | input | 1 | Reader response this cycle |
| rdr_resp_eom | input | 1 | Response reports end of media instead of a character |
| rdr_resp_char | input | 8 | Character carried by the response |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume the reader responds only after it has seen a strobe, and holds `rdr_resp_valid` for one cycle. They also assume a buffer read or enable write does not land on the same edge as a completion, because the completion wins there and the clearing checks exclude it. The bench drives every response one full cycle after the strobe cycle, with the bus idle. It changes `rdr_media` only while no read is pending, and it spaces bus accesses apart from completions.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;

  localparam int ERR_BIT  = 15;
  localparam int BUSY_BIT = 11;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int GO_BIT   = 0;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CSR  = 2'd1,
    SEL_BUF  = 2'd2
  } sel_e;

  function automatic logic [WORD_W-1:0] status_word(input logic err, input logic busy,
                                                    input logic done, input logic ie);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ERR_BIT]  = err;
    w[BUSY_BIT] = busy;
    w[DONE_BIT] = done;
    w[IE_BIT]   = ie;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] buffer_word(input logic [CHAR_W-1:0] ch);
    return {{(WORD_W-CHAR_W){1'b0}}, ch};
  endfunction
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import ptr_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CSR_WORD = 4,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  output sel_e              sel,
  output logic              nxm,
  output logic              ev_csr_wr,
  output logic              ev_buf_rd
);
  localparam logic [IDX_W-1:0] CSR_IDX = IDX_W'(CSR_WORD);
  localparam logic [IDX_W-1:0] BUF_IDX = IDX_W'(CSR_WORD + 1);

  logic [IDX_W-1:0] idx;
  logic             odd_byte;

  assign idx      = bus_addr[ADDR_W-1:1];
  assign odd_byte = bus_byte && bus_addr[0];

  always_comb begin
    sel = SEL_NONE;
    if (bus_valid) begin
      if (idx == CSR_IDX)      sel = SEL_CSR;
      else if (idx == BUF_IDX) sel = SEL_BUF;
    end
  end

  assign nxm       = bus_valid && (sel == SEL_NONE);
  assign ev_csr_wr = (sel == SEL_CSR) && bus_write && !odd_byte;
  assign ev_buf_rd = (sel == SEL_BUF) && !bus_write;

  always_comb begin
    if (bus_valid) begin
      assert_one_target_R1: assert ($onehot({nxm, sel == SEL_CSR, sel == SEL_BUF}));
    end
  end
endmodule

// File: rtl/ptr_seq.sv
module ptr_seq
  import ptr_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          media,
  input  logic          ev_start,
  input  logic          ev_buf_rd,
  input  logic          resp_valid,
  input  logic          resp_eom,
  input  logic [CW-1:0] resp_char,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] char_q,
  output logic          strobe,
  output logic          ev_complete
);
  rd_state_e state;
  logic      ev_fail_nomedia;
  logic      ev_resp;

  assign ev_fail_nomedia = (state == RD_ISSUE) && !media && !ev_start;
  assign ev_resp         = (state == RD_WAIT) && resp_valid && !ev_start;
  assign ev_complete     = ev_fail_nomedia || ev_resp;
  assign strobe          = (state == RD_ISSUE) && media;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= !media;
      char_q <= '0;
    end else begin
      if (ev_buf_rd) done <= 1'b0;
      if (ev_start) begin
        state <= RD_ISSUE;
        busy  <= 1'b1;
        done  <= 1'b0;
      end else begin
        case (state)
          RD_ISSUE: begin
            if (!media) begin
              state <= RD_IDLE;
              busy  <= 1'b0;
              err   <= 1'b1;
            end else begin
              state <= RD_WAIT;
            end
          end
          RD_WAIT: begin
            if (resp_valid) begin
              state <= RD_IDLE;
              busy  <= 1'b0;
              if (resp_eom) begin
                err <= 1'b1;
              end else begin
                err    <= 1'b0;
                done   <= 1'b1;
                char_q <= resp_char;
              end
            end
          end
          default: state <= RD_IDLE;
        endcase
      end
    end
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (busy && !done));
  assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);
  assert_nomedia_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail_nomedia |=> (err && !busy));
  assert_char_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp && !resp_eom) |=> (done && !err && !busy && char_q == $past(resp_char)));
  assert_eom_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp && resp_eom) |=> (err && !done && !busy));
endmodule

// File: rtl/ptr_irq.sv
module ptr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ie_wr,
  input  logic wr_ie,
  input  logic ev_start,
  input  logic ev_buf_rd,
  input  logic ev_complete,
  input  logic err,
  input  logic done,
  output logic ie,
  output logic irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (ev_ie_wr) begin
      if (!wr_ie)                    irq_d = 1'b0;
      else if (!ie && (err || done)) irq_d = 1'b1;
    end
    if (ev_start)             irq_d = 1'b0;
    if (ev_buf_rd)            irq_d = 1'b0;
    if (ev_complete && ie)    irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
      if (ev_ie_wr) ie <= wr_ie;
    end
  end

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_complete || ev_ie_wr));
  assert_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ie_wr && !wr_ie && !ev_complete) |=> !irq);
  assert_bufrd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_rd && !ev_complete) |=> !irq);
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !irq);
endmodule

// File: rtl/ptr_reader_if.sv
module ptr_reader_if
  import ptr_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CSR_WORD = 4,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_nxm,
  input  logic              rdr_media,
  output logic              rdr_strobe,
  input  logic              rdr_resp_valid,
  input  logic              rdr_resp_eom,
  input  logic [7:0]        rdr_resp_char,
  output logic              irq
);
  sel_e        sel;
  logic        ev_csr_wr;
  logic        ev_buf_rd_raw;
  logic        ev_buf_rd;
  logic        ev_start;
  logic        ev_complete;
  logic        busy;
  logic        done;
  logic        err;
  logic        ie;
  logic [7:0]  char_q;

  ptr_decode #(.IDX_W(IDX_W), .CSR_WORD(CSR_WORD)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .sel       (sel),
    .nxm       (bus_nxm),
    .ev_csr_wr (ev_csr_wr),
    .ev_buf_rd (ev_buf_rd_raw)
  );

  assign ev_buf_rd = ev_buf_rd_raw;
  assign ev_start  = ev_csr_wr && bus_wdata[GO_BIT];

  ptr_seq #(.CW(CHAR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .media       (rdr_media),
    .ev_start    (ev_start),
    .ev_buf_rd   (ev_buf_rd),
    .resp_valid  (rdr_resp_valid),
    .resp_eom    (rdr_resp_eom),
    .resp_char   (rdr_resp_char),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .char_q      (char_q),
    .strobe      (rdr_strobe),
    .ev_complete (ev_complete)
  );

  ptr_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_ie_wr    (ev_csr_wr),
    .wr_ie       (bus_wdata[IE_BIT]),
    .ev_start    (ev_start),
    .ev_buf_rd   (ev_buf_rd),
    .ev_complete (ev_complete),
    .err         (err),
    .done        (done),
    .ie          (ie),
    .irq         (irq)
  );

  always_comb begin
    case (sel)
      SEL_CSR: bus_rdata = status_word(err, busy, done, ie);
      SEL_BUF: bus_rdata = buffer_word(char_q);
      default: bus_rdata = '0;
    endcase
  end

  assert_no_done_with_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_nxm_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nxm |-> (!ev_csr_wr && !ev_buf_rd));
endmodule

// File: tb/ptr_reader_if_bench.sv
module ptr_reader_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_byte = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_nxm;
  logic        rdr_media = 1'b0;
  logic        rdr_strobe;
  logic        rdr_resp_valid = 1'b0;
  logic        rdr_resp_eom = 1'b0;
  logic [7:0]  rdr_resp_char = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [4:0]  A_CSR = 5'd8;
  localparam logic [4:0]  A_BUF = 5'd10;
  localparam logic [15:0] S_ERR  = 16'h8000;
  localparam logic [15:0] S_BUSY = 16'h0800;
  localparam logic [15:0] S_DONE = 16'h0080;
  localparam logic [15:0] S_IE   = 16'h0040;

  always #2 clk = ~clk;

  ptr_reader_if u_ptr_reader_if (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_nxm(bus_nxm), .rdr_media(rdr_media),
    .rdr_strobe(rdr_strobe), .rdr_resp_valid(rdr_resp_valid),
    .rdr_resp_eom(rdr_resp_eom), .rdr_resp_char(rdr_resp_char), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d, output logic nx);
    bus_valid = 1'b1; bus_write = 1'b0; bus_byte = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; nx = bus_nxm;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d, input logic bytew);
    bus_valid = 1'b1; bus_write = 1'b1; bus_byte = bytew; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic respond(input logic eom, input logic [7:0] ch);
    rdr_resp_valid = 1'b1; rdr_resp_eom = eom; rdr_resp_char = ch;
    @(negedge clk);
    rdr_resp_valid = 1'b0; rdr_resp_eom = 1'b0;
  endtask

  task automatic status(input string tag, input logic [15:0] exp);
    logic [15:0] d; logic nx;
    bus_rd(A_CSR, d, nx);
    chk(tag, d, exp);
  endtask

  task automatic do_reset(input logic media);
    rdr_media = media;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_states;
    logic [15:0] d; logic nx;
    do_reset(1'b0);
    status("R11 reset no media err set", S_ERR);
    chk("R11 reset irq low", {15'd0, irq}, 16'd0);
    bus_rd(A_BUF, d, nx);
    chk("R11 reset buffer zero", d, 16'h0000);
    do_reset(1'b1);
    status("R11 reset with media clear", 16'h0000);
  endtask

  task automatic t_read_char;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR, 16'h0001, 1'b0);
    chk("R3 strobe after start", {15'd0, rdr_strobe}, 16'd1);
    status("R3 R2 busy while pending", S_BUSY);
    chk("R3 strobe single cycle", {15'd0, rdr_strobe}, 16'd0);
    respond(1'b0, 8'hA5);
    status("R5 done after char", S_DONE);
    chk("R6 no irq when disabled", {15'd0, irq}, 16'd0);
    bus_rd(A_BUF, d, nx);
    chk("R7 buffer value", d, 16'h00A5);
    chk("R1 buffer not nxm", {15'd0, nx}, 16'd0);
    status("R7 done cleared by buffer read", 16'h0000);
  endtask

  task automatic t_read_irq;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR, 16'h0041, 1'b0);
    @(negedge clk);
    respond(1'b0, 8'h3C);
    chk("R6 irq on completion", {15'd0, irq}, 16'd1);
    status("R5 R2 done and ie", S_DONE | S_IE);
    bus_rd(A_BUF, d, nx);
    chk("R7 buffer second char", d, 16'h003C);
    chk("R7 irq withdrawn by buffer read", {15'd0, irq}, 16'd0);
    status("R7 done clear ie kept", S_IE);
  endtask

  task automatic t_eom;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR, 16'h0041, 1'b0);
    @(negedge clk);
    respond(1'b1, 8'h77);
    status("R5 end of media error", S_ERR | S_IE);
    chk("R6 irq on eom", {15'd0, irq}, 16'd1);
    bus_rd(A_BUF, d, nx);
    chk("R5 buffer unchanged on eom", d, 16'h003C);
  endtask

  task automatic t_nomedia;
    bus_wr(A_CSR, 16'h0040, 1'b0);
    bus_wr(A_CSR, 16'h0000, 1'b0);
    bus_wr(A_CSR, 16'h0040, 1'b0);
    chk("R9 irq raised by enabling with err", {15'd0, irq}, 16'd1);
    rdr_media = 1'b0;
    bus_wr(A_CSR, 16'h0041, 1'b0);
    chk("R3 start withdraws irq", {15'd0, irq}, 16'd0);
    chk("R4 no strobe without media", {15'd0, rdr_strobe}, 16'd0);
    status("R4 busy before failing", S_ERR | S_BUSY | S_IE);
    status("R4 failed read", S_ERR | S_IE);
    chk("R4 irq on failure", {15'd0, irq}, 16'd1);
    rdr_media = 1'b1;
  endtask

  task automatic t_ie_rules;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR, 16'h0000, 1'b0);
    chk("R9 ie write 0 withdraws", {15'd0, irq}, 16'd0);
    bus_wr(A_CSR, 16'h0040, 1'b0);
    chk("R9 ie 0 to 1 raises", {15'd0, irq}, 16'd1);
    bus_rd(A_BUF, d, nx);
    chk("R7 buffer read drops irq", {15'd0, irq}, 16'd0);
    bus_wr(A_CSR, 16'h0040, 1'b0);
    chk("R9 ie 1 to 1 no raise", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_ignored_writes;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR + 5'd1, 16'hFFFF, 1'b1);
    chk("R10 odd byte no strobe", {15'd0, rdr_strobe}, 16'd0);
    status("R10 odd byte no effect", S_ERR | S_IE);
    bus_wr(A_BUF, 16'h00FF, 1'b0);
    bus_rd(A_BUF, d, nx);
    chk("R8 buffer write ignored", d, 16'h003C);
    status("R8 status unchanged", S_ERR | S_IE);
  endtask

  task automatic t_nxm;
    logic [15:0] d; logic nx;
    bus_rd(5'd6, d, nx);
    chk("R1 undecoded read nxm", {15'd0, nx}, 16'd1);
    bus_valid = 1'b1; bus_write = 1'b1; bus_byte = 1'b0; bus_addr = 5'd14; bus_wdata = 16'h0001;
    #1;
    chk("R1 undecoded write nxm", {15'd0, bus_nxm}, 16'd1);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R1 undecoded write no strobe", {15'd0, rdr_strobe}, 16'd0);
    bus_rd(A_CSR, d, nx);
    chk("R1 status decoded not nxm", {15'd0, nx}, 16'd0);
    chk("R1 status unchanged after nxm", d, S_ERR | S_IE);
  endtask

  task automatic t_reset_cancel;
    logic [15:0] d; logic nx;
    bus_wr(A_CSR, 16'h0041, 1'b0);
    @(negedge clk);
    do_reset(1'b1);
    respond(1'b0, 8'h5A);
    status("R11 cancelled read ignores response", 16'h0000);
    bus_rd(A_BUF, d, nx);
    chk("R11 buffer stays zero", d, 16'h0000);
    chk("R11 irq low after cancel", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_start_clears_done;
    bus_wr(A_CSR, 16'h0041, 1'b0);
    @(negedge clk);
    respond(1'b0, 8'h11);
    chk("R6 irq before restart", {15'd0, irq}, 16'd1);
    bus_wr(A_CSR, 16'h0041, 1'b0);
    chk("R3 restart drops irq", {15'd0, irq}, 16'd0);
    status("R3 restart clears done sets busy", S_BUSY | S_IE);
    respond(1'b0, 8'h22);
    status("R5 second completion", S_DONE | S_IE);
  endtask

  initial begin
    #(4 * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_states();
    t_read_char();
    t_read_irq();
    t_eom();
    t_nomedia();
    t_ie_rules();
    t_ignored_writes();
    t_nxm();
    t_reset_cancel();
    t_start_clears_done();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule